// File: doc/BRIEF.md
# Multiply/Divide Coprocessor

A byte-wide arithmetic peripheral for a small processor bus. It holds five operand/result bytes and one control/status byte in a six-byte window. It computes an unsigned 16x8 product (24 bits) or an unsigned 24/16 quotient (16 bits). Software fills the operand bytes, then writes a start bit to the control byte. The unit stays busy for a fixed number of instruction cycles, writes its result back into the operand bytes, and clears its start bits.

Every multi-byte value is stored least significant byte first. The window starts at `BASE_ADDR`, which is 0x98 by default. A divide whose quotient would not fit in 16 bits, or one whose divisor is zero, is found before any division takes place. Such a divide finishes early, raises a read-only overflow flag, and leaves every operand byte as it was. While the unit is busy, the bus cannot alter any register.

Top module: `muldiv_copro`

## Requirements
- R1: After reset the control byte (offset 0x9D) reads 0x00, and an operand write issued right after reset takes effect.
- R2: Writing 1 to control bit 0 starts a multiply. The multiplicand is {0x9C (high), 0x9B (low)} and the multiplier is 0x99. The 24-bit product goes to 0x99 (low), 0x9A and 0x9B (high). Bytes 0x98 and 0x9C keep their values.
- R3: Writing 1 to control bit 1 starts a divide. The dividend is {0x9A, 0x99, 0x98}, lowest offset least significant, and the divisor is {0x9C, 0x9B}. When there is no error, the 16-bit quotient goes to 0x98 (low) and 0x99 (high). Bytes 0x9A to 0x9C keep their values.
- R4: A control write with bits 0 and 1 both set performs a divide.
- R5: When any operation ends, control bits 0 and 1 both read 0.
- R6: A multiply, and a divide that ends in error, each take `CYC_CLKS` clocks. A divide without error takes 2x`CYC_CLKS` clocks. Read data is registered, so it appears one clock after the address is presented. A read issued while the unit is busy returns 0x00.
- R7: A divide with a zero divisor, or with a quotient of 2^16 or more, sets control bit 2 and leaves all five operand bytes unchanged. A divide without error clears bit 2.
- R8: Every multiply clears control bit 2.
- R9: Writes cannot change control bit 2. Control bits 7..3 always read 0. A control write with bits 0 and 1 both clear starts nothing.
- R10: While an operation runs, writes to the operand bytes and to the control byte are ignored.
- R11: A reset during an operation aborts it. The control byte reads 0x00 afterwards, and no result is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | AW | Byte address for both reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for the address of the previous cycle |

## Verification
A wrong sequencer count shows up at the ports as a result byte that becomes readable one clock too early or too late. The bench measures this edge by polling a result byte or the control byte on every clock after the start. A wrong operand capture or a misplaced result byte corrupts the product or quotient the first time it is read back. Mixing random operands with chosen corner cases (zero divisor, a quotient just at the limit, both start bits set, writes issued while busy, reset mid-operation) exposes each fault within one operation.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_OPR  = 5;
  localparam int CTRL_IDX = 5;
  localparam int IDX_W    = 3;
  localparam int MCAND_W  = 16;
  localparam int MPLR_W   = 8;
  localparam int PROD_W   = MCAND_W + MPLR_W;
  localparam int DVD_W    = 24;
  localparam int DVS_W    = 16;
  localparam int QUO_W    = 16;
  localparam int B_MUL    = 0;
  localparam int B_DIV    = 1;
  localparam int B_OVF    = 2;
endpackage

// File: rtl/mdc_mul.sv
module mdc_mul #(
  parameter int A_W = 16,
  parameter int B_W = 8
) (
  input  logic [A_W-1:0]     mcand,
  input  logic [B_W-1:0]     mplr,
  output logic [A_W+B_W-1:0] prod
);
  localparam int P_W = A_W + B_W;

  // shift-and-add partial products, one row per multiplier bit
  logic [P_W-1:0] row [B_W];
  logic [P_W-1:0] acc [B_W+1];

  assign acc[0] = '0;
  for (genvar g = 0; g < B_W; g++) begin : g_row
    assign row[g]   = mplr[g] ? (P_W'(mcand) << g) : '0;
    assign acc[g+1] = acc[g] + row[g];
  end
  assign prod = acc[B_W];
endmodule

// File: rtl/mdc_div.sv
module mdc_div #(
  parameter int DD_W = 24,
  parameter int DS_W = 16,
  parameter int Q_W  = 16
) (
  input  logic [DD_W-1:0] dvd,
  input  logic [DS_W-1:0] dvs,
  output logic            err,
  output logic [Q_W-1:0]  quo
);
  localparam int HI_W = DD_W - Q_W;

  logic [DS_W:0] rem;
  logic [DS_W:0] trial;

  // quotient needs more than Q_W bits exactly when top HI_W bits >= divisor;
  // a zero divisor always satisfies this
  assign err = (DS_W'(dvd[DD_W-1:Q_W]) >= dvs);

  always_comb begin
    rem   = (DS_W+1)'(dvd[DD_W-1:Q_W]);
    trial = '0;
    quo   = '0;
    for (int i = Q_W - 1; i >= 0; i--) begin
      trial = {rem[DS_W-1:0], dvd[i]};
      if (trial >= {1'b0, dvs}) begin
        rem    = trial - {1'b0, dvs};
        quo[i] = 1'b1;
      end else begin
        rem = trial;
      end
    end
  end

  initial begin
    assert (HI_W <= DS_W) else $error("dividend upper part wider than divisor");
  end
endmodule

// File: rtl/mdc_seq.sv
module mdc_seq #(
  parameter int CYC_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic go_mul,
  input  logic go_div,
  input  logic div_err,
  output logic busy,
  output logic done,
  output logic op_div
);
  localparam int LW = $clog2(2 * CYC_CLKS + 1);
  localparam logic [LW-1:0] SHORT_LAST = LW'(CYC_CLKS - 1);
  localparam logic [LW-1:0] LONG_LAST  = LW'(2 * CYC_CLKS - 1);

  logic [LW-1:0] cnt;
  logic [LW-1:0] last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      last   <= '0;
      op_div <= 1'b0;
    end else if (!busy) begin
      if (go_mul || go_div) begin
        busy   <= 1'b1;
        cnt    <= '0;
        op_div <= go_div;
        last   <= (go_div && !div_err) ? LONG_LAST : SHORT_LAST;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = busy && (cnt == last);

  // R4
  div_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && go_mul && go_div) |=> (busy && op_div));

  // R6
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  // R6
  end_drop_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: rtl/muldiv_copro.sv
module muldiv_copro
  import mdc_pkg::*;
#(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] BASE_ADDR = 'h98,
  parameter int            CYC_CLKS  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [AW-1:0]    off;
  logic [IDX_W-1:0] idx;
  logic             in_rf, in_ctl;
  logic             busy, done, op_div;
  logic             go_mul, go_div, ctl_wr;
  logic             mul_b, div_b, ovf;
  logic             dv_err;
  logic [BYTE_W-1:0] rf [NUM_OPR];
  logic [NUM_OPR*BYTE_W-1:0] rf_flat;
  logic [PROD_W-1:0] prod;
  logic [QUO_W-1:0]  quo;

  assign off    = addr - BASE_ADDR;
  assign idx    = off[IDX_W-1:0];
  assign in_rf  = off < AW'(NUM_OPR);
  assign in_ctl = off == AW'(CTRL_IDX);
  assign ctl_wr = wr_en && in_ctl && !busy;
  assign go_div = ctl_wr && wdata[B_DIV];
  assign go_mul = ctl_wr && wdata[B_MUL];

  for (genvar g = 0; g < NUM_OPR; g++) begin : g_flat
    assign rf_flat[g*BYTE_W +: BYTE_W] = rf[g];
  end

  mdc_mul #(.A_W(MCAND_W), .B_W(MPLR_W)) u_mul (
    .mcand ({rf[4], rf[3]}),
    .mplr  (rf[1]),
    .prod  (prod)
  );

  mdc_div #(.DD_W(DVD_W), .DS_W(DVS_W), .Q_W(QUO_W)) u_div (
    .dvd ({rf[2], rf[1], rf[0]}),
    .dvs ({rf[4], rf[3]}),
    .err (dv_err),
    .quo (quo)
  );

  mdc_seq #(.CYC_CLKS(CYC_CLKS)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .go_mul  (go_mul),
    .go_div  (go_div),
    .div_err (dv_err),
    .busy    (busy),
    .done    (done),
    .op_div  (op_div)
  );

  // operand/result bytes: no reset, contents undefined after reset
  always_ff @(posedge clk) begin
    if (!rst) begin
      if (done && !op_div) begin
        rf[1] <= prod[7:0];
        rf[2] <= prod[15:8];
        rf[3] <= prod[23:16];
      end else if (done && op_div && !dv_err) begin
        rf[0] <= quo[7:0];
        rf[1] <= quo[15:8];
      end else if (wr_en && !busy && in_rf) begin
        rf[idx] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mul_b <= 1'b0;
      div_b <= 1'b0;
      ovf   <= 1'b0;
    end else if (done) begin
      mul_b <= 1'b0;
      div_b <= 1'b0;
      ovf   <= op_div ? dv_err : 1'b0;
    end else if (ctl_wr) begin
      mul_b <= wdata[B_MUL];
      div_b <= wdata[B_DIV];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (busy)
      rdata <= '0;
    else if (in_rf)
      rdata <= rf[idx];
    else if (in_ctl)
      rdata <= {5'b0, ovf, div_b, mul_b};
    else
      rdata <= '0;
  end

  // R8
  mul_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !op_div) |=> !ovf);

  // R5
  start_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!mul_b && !div_b));

  // R7
  err_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_div && dv_err) |=> ($stable(rf_flat) && ovf));

  // R10
  busy_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && wr_en) |=> ($stable(rf_flat) && $stable({mul_b, div_b, ovf})));

  // R6
  busy_rd_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> (rdata == 8'h00));
endmodule

// File: tb/sim_muldiv_copro.sv
module sim_muldiv_copro;
  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 4;
  localparam logic [7:0] A_CTL = 8'h9D;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int total = 0;
  int fails = 0;
  logic [7:0] m [5];
  logic       ovf_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_copro #(.AW(8), .BASE_ADDR(8'h98), .CYC_CLKS(CYC)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic load(input logic [7:0] b0, b1, b2, b3, b4);
    wr(8'h98, b0); wr(8'h99, b1); wr(8'h9A, b2); wr(8'h9B, b3); wr(8'h9C, b4);
    m[0] = b0; m[1] = b1; m[2] = b2; m[3] = b3; m[4] = b4;
  endtask

  // bench model of one completed operation
  function automatic void model_op(input logic [7:0] ctl);
    logic [23:0] p, dd, q;
    logic [15:0] ds;
    if (ctl[1]) begin
      dd = {m[2], m[1], m[0]};
      ds = {m[4], m[3]};
      if (ds == 16'h0) ovf_m = 1'b1;
      else begin
        q = dd / {8'h0, ds};
        if (q > 24'h00FFFF) ovf_m = 1'b1;
        else begin
          ovf_m = 1'b0; m[0] = q[7:0]; m[1] = q[15:8];
        end
      end
    end else if (ctl[0]) begin
      p = {8'h0, m[4], m[3]} * {16'h0, m[1]};
      m[1] = p[7:0]; m[2] = p[15:8]; m[3] = p[23:16];
      ovf_m = 1'b0;
    end
  endfunction

  task automatic verify_all(input string req);
    logic [7:0] v;
    for (int i = 0; i < 5; i++) begin
      rd(8'h98 + 8'(i), v);
      check(req, v, m[i]);
    end
    rd(A_CTL, v);
    check(req, v, {5'b0, ovf_m, 2'b00});
  endtask

  task automatic run_op(input logic [7:0] ctl, input string req);
    wr(A_CTL, ctl);
    repeat (2 * CYC + 2) @(negedge clk);
    model_op(ctl);
    verify_all(req);
  endtask

  // returns the first clock after the start edge at which rdata is nonzero
  task automatic first_seen(input logic [7:0] ctl, input logic [7:0] watch, output int k_out);
    @(negedge clk);
    addr = A_CTL; wdata = ctl; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = watch;
    k_out = 0;
    for (int k = 2; k <= 3 * CYC + 2; k++) begin
      @(negedge clk);
      if (k_out == 0 && rdata != 8'h00) k_out = k - 1;
    end
    model_op(ctl);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int k;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state and immediate write acceptance
    rd(A_CTL, v); check("R1 ctrl after reset", v, 8'h00);
    wr(8'h98, 8'h5A); rd(8'h98, v); check("R1 write after reset", v, 8'h5A);

    // R2 directed multiply at max operands
    load(8'h11, 8'hFF, 8'h00, 8'hFF, 8'hFF);
    run_op(8'h01, "R2 mul max");
    check("R2 mul hi byte", m[3], 8'hFE);

    // R3 directed divide at quotient limit 0xFFFF
    load(8'hFF, 8'hFE, 8'hFF, 8'h02, 8'h00);  // 0xFFFEFF / 2 = 0x7FFF7F
    run_op(8'h02, "R7 div overflow");
    load(8'h01, 8'h00, 8'h01, 8'h01, 8'h01);  // 0x010001 / 0x0101 = 0xFF
    run_op(8'h02, "R3 div");
    load(8'hFE, 8'hFF, 8'hFE, 8'hFF, 8'h00);  // 0xFEFFFE / 0xFF = 0xFFFF rem 0xFD... fits
    run_op(8'h02, "R3 div at limit");

    // R7 divide by zero keeps operands
    load(8'h12, 8'h34, 8'h56, 8'h00, 8'h00);
    run_op(8'h02, "R7 div by zero");

    // R9 flag is read-only, reserved bits zero, no start
    wr(A_CTL, 8'hF8); rd(A_CTL, v); check("R9 flag kept set", v, 8'h04);
    rd(8'h99, v); check("R9 no op started", v, m[1]);
    // R8 multiply clears flag
    load(8'h00, 8'h03, 8'h00, 8'h07, 8'h00);
    run_op(8'h01, "R8 mul clears flag");
    wr(A_CTL, 8'hFC); rd(A_CTL, v); check("R9 flag not settable", v, 8'h00);

    // R4 both start bits -> divide
    load(8'h64, 8'h00, 8'h00, 8'h05, 8'h00);
    run_op(8'h03, "R4 both bits divide");
    check("R4 quotient", m[0], 8'h14);

    // R6 timing, R5 start bits clear
    load(8'h00, 8'h05, 8'h00, 8'h01, 8'h00);
    first_seen(8'h01, 8'h99, k); check("R6 mul latency", 8'(k), 8'(CYC + 1));
    rd(A_CTL, v); check("R5 bits cleared after mul", v, 8'h00);
    load(8'h64, 8'h00, 8'h00, 8'h05, 8'h00);
    first_seen(8'h02, 8'h98, k); check("R6 div latency", 8'(k), 8'(2 * CYC + 1));
    rd(A_CTL, v); check("R5 bits cleared after div", v, 8'h00);
    load(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    first_seen(8'h02, A_CTL, k); check("R6 error div latency", 8'(k), 8'(CYC + 1));
    verify_all("R7 zero operands kept");

    // R10 writes during busy ignored
    load(8'h00, 8'h09, 8'h00, 8'h21, 8'h03);
    wr(A_CTL, 8'h01);
    wr(8'h9C, 8'hFF);
    wr(A_CTL, 8'h02);
    repeat (2 * CYC + 2) @(negedge clk);
    model_op(8'h01);
    verify_all("R10 busy writes ignored");

    // R11 reset mid-operation
    load(8'h01, 8'h02, 8'h03, 8'h04, 8'h05);
    wr(A_CTL, 8'h01);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    ovf_m = 1'b0;
    repeat (2 * CYC + 2) @(negedge clk);
    verify_all("R11 aborted op");
    wr(8'h9A, 8'h77); rd(8'h9A, v); check("R11 idle after abort", v, 8'h77);
    m[2] = 8'h77;

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [7:0] ctl;
      logic [15:0] ds;
      ds = 16'($urandom) >> ($urandom % 16);
      load(8'($urandom), 8'($urandom), 8'($urandom), ds[7:0], ds[15:8]);
      case ($urandom % 3)
        0: ctl = 8'h01;
        1: ctl = 8'h02;
        default: ctl = 8'h03;
      endcase
      run_op(ctl, ctl == 8'h01 ? "R2 random mul" : "R3 random div");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule